// File: doc/BRIEF.md
# PCI Power-Management Configuration Slice

This block holds the part of a PCI function's configuration space that deals with power management. It answers configuration reads and writes for four dwords. The first holds the command register and the status register. The status register flags that a capability list exists, and its error flags are cleared by writing a one. The second dword holds the capability list pointer. The last two hold the only entry in the list, a power-management capability, and its control/status word.

The control/status word carries a two-bit power-state field. Software can move the function between the full-power state D0 and the low-power state D3hot. While the function sits in D3hot, the block turns off the enable for the functional clock and its PLL, holds the function's soft reset asserted, and keeps the command register at zero. The D1 and D2 states are not offered, and no power-management event signalling is provided: every field that would describe such support reads as zero.

The configuration port takes a dword address, four byte enables and a write strobe. Read data is returned one cycle after the request. Error events from the rest of the function enter on a small pulse vector and set the matching status flags.

Top module: `pcipm_cfg_slice`

## Requirements
- R1: After reset the power state is D0, `func_clk_en` and `pll_en` are 1, `soft_rst` is 0, `cmd_reg` is 0 and every status error flag is 0.
- R2: A read of dword 0Dh (byte offset 34h) returns 0000_0040h, which points the capability list at byte 40h.
- R3: A read of dword 10h returns 0001_0001h: capability ID 01h in bits 7:0, next pointer 00h in bits 15:8, and capabilities 0001h in bits 31:16 (version 001b, every D1, D2, event, auxiliary-power and special-initialisation field zero).
- R4: A read of dword 11h returns the power-state code in bits 1:0 (00b for D0, 11b for D3hot), with all other bits zero. A write to the power-state field needs byte enable 0.
- R5: In the status half of dword 01h (bits 31:16), status bit 4 always reads 1 and bits 10:9 always read the DEVSEL_TIMING parameter (01b by default). All other non-error bits read 0, and writes have no effect on any of them.
- R6: `err_set[0..4]` set status bits 8, 12, 13, 14 and 15. A write to dword 01h with byte enable 3 clears each of these bits whose data bit (bit position + 16) is 1 and leaves the rest unchanged. A set and a clear of the same bit in the same cycle leave the bit set.
- R7: Once a write of 11b to the power-state field has been accepted, from the next cycle and for as long as the state stays D3hot, `soft_rst` is 1 and `func_clk_en` and `pll_en` are 0.
- R8: Moving from D0 to D3hot clears `cmd_reg` to zero in the same cycle as the state changes.
- R9: Writes to the command register are ignored while the state is D3hot.
- R10: Writes of the reserved codes 01b and 10b to the power-state field are ignored, and the state is kept.
- R11: Writing 00b from D3hot returns to D0. From the next cycle `soft_rst` is 0 and the enables are 1, but `cmd_reg` stays 0 until it is written again.
- R12: The command register (bits 15:0 of dword 01h) takes each byte only when that byte's enable is set. Bits outside CMD_WR_MASK (0547h by default) always read 0.
- R13: Every read returns data with `cfg_rvalid` high exactly one cycle after the request. Dwords 0Dh, 10h and 11h (apart from the power-state field) ignore writes, and all other dwords read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_req | input | 1 | Configuration access request, one cycle per access |
| cfg_we | input | 1 | 1 for write, 0 for read |
| cfg_dw_addr | input | ADDR_W | Dword address within configuration space |
| cfg_be | input | 4 | Byte enables for writes |
| cfg_wdata | input | 32 | Write data |
| err_set | input | 5 | Error event pulses that set status flags |
| cfg_rvalid | output | 1 | Read data valid |
| cfg_rdata | output | 32 | Read data |
| cmd_reg | output | 16 | Current command register value |
| func_clk_en | output | 1 | Functional clock enable |
| pll_en | output | 1 | PLL enable |
| soft_rst | output | 1 | Soft reset to the function |

## Verification
The assertions assume that at most one access, read or write, arrives per cycle, and that the power state changes only through the configuration port. Under these assumptions the read-back power-state code always matches `soft_rst`. The stimulus drives every access for exactly one cycle and leaves an idle cycle between accesses. It raises error pulses only in cycles the bench picks on purpose, including one that collides with a clearing write.

// File: rtl/pcipm_pkg.sv
package pcipm_pkg;

   // dword locations decoded by the slice
   localparam int unsigned DW_CMDSTS = 1;
   localparam int unsigned DW_CAPPTR = 13;
   localparam int unsigned DW_PMCAP  = 16;
   localparam int unsigned DW_PMCSR  = 17;

   localparam logic [7:0]  CAP_LIST_START = 8'h40;
   localparam logic [7:0]  CAP_ID_PWRMGT  = 8'h01;
   localparam logic [7:0]  CAP_NEXT_NONE  = 8'h00;
   localparam logic [15:0] PWRMGT_CAPS    = 16'h0001;

   // status error flags and their bit positions, lowest input index first
   localparam int unsigned ERR_N = 5;
   localparam int unsigned ERR_BIT [ERR_N] = '{8, 12, 13, 14, 15};

   typedef enum logic [1:0] {
      PS_D0    = 2'b00,
      PS_D3HOT = 2'b11
   } pstate_e;

endpackage

// File: rtl/pcipm_status.sv
module pcipm_status
   import pcipm_pkg::*;
#(
   parameter logic [1:0] DEVSEL = 2'b01
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_stb,
   input  logic [7:0]       clr_byte,
   input  logic [ERR_N-1:0] err_set,
   output logic [15:0]      status
);

   logic [ERR_N-1:0] err_q;

   for (genvar i = 0; i < ERR_N; i++) begin : g_err
      localparam int unsigned POS = ERR_BIT[i];
      if (POS < 8 || POS > 15) begin : g_bad
         $error("status error flag must sit in the upper status byte");
      end
      logic q;
      always_ff @(posedge clk) begin
         if (!rst_n)                        q <= 1'b0;
         else if (err_set[i])               q <= 1'b1;
         else if (clr_stb && clr_byte[POS-8]) q <= 1'b0;
      end
      assign err_q[i] = q;
   end

   always_comb begin
      status       = '0;
      status[4]    = 1'b1;
      status[10:9] = DEVSEL;
      for (int i = 0; i < ERR_N; i++) status[ERR_BIT[i]] = err_q[i];
   end

endmodule

// File: rtl/pcipm_cmd.sv
module pcipm_cmd #(
   parameter logic [15:0] WR_MASK = 16'h0547
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_stb,
   input  logic [1:0]  be,
   input  logic [15:0] wdata,
   input  logic        hold,
   input  logic        clr,
   output logic [15:0] cmd
);

   localparam int unsigned NBYTE = 2;

   for (genvar b = 0; b < NBYTE; b++) begin : g_byte
      logic [7:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n)                        q <= '0;
         else if (clr)                      q <= '0;
         else if (wr_stb && be[b] && !hold) q <= wdata[b*8 +: 8] & WR_MASK[b*8 +: 8];
      end
      assign cmd[b*8 +: 8] = q;
   end

endmodule

// File: rtl/pcipm_pstate.sv
module pcipm_pstate
   import pcipm_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_stb,
   input  logic [1:0] code,
   output pstate_e    state,
   output logic       enter_d3,
   output logic       func_clk_en,
   output logic       pll_en,
   output logic       soft_rst
);

   logic accept;
   logic asleep;

   assign accept   = wr_stb && (code == PS_D0 || code == PS_D3HOT);
   assign enter_d3 = accept && (code == PS_D3HOT) && (state == PS_D0);

   always_ff @(posedge clk) begin
      if (!rst_n)      state <= PS_D0;
      else if (accept) state <= pstate_e'(code);
   end

   assign asleep      = (state == PS_D3HOT);
   assign soft_rst    = asleep;
   assign func_clk_en = !asleep;
   assign pll_en      = !asleep;

endmodule

// File: rtl/pcipm_cfg_slice.sv
module pcipm_cfg_slice
   import pcipm_pkg::*;
#(
   parameter int unsigned ADDR_W        = 6,
   parameter logic [15:0] CMD_WR_MASK   = 16'h0547,
   parameter logic [1:0]  DEVSEL_TIMING = 2'b01
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_req,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_dw_addr,
   input  logic [3:0]        cfg_be,
   input  logic [31:0]       cfg_wdata,
   input  logic [ERR_N-1:0]  err_set,
   output logic              cfg_rvalid,
   output logic [31:0]       cfg_rdata,
   output logic [15:0]       cmd_reg,
   output logic              func_clk_en,
   output logic              pll_en,
   output logic              soft_rst
);

   if (ADDR_W < 5) begin : g_addr_chk
      $error("ADDR_W too small to reach the control/status dword");
   end

   localparam logic [ADDR_W-1:0] A_CMDSTS = ADDR_W'(DW_CMDSTS);
   localparam logic [ADDR_W-1:0] A_CAPPTR = ADDR_W'(DW_CAPPTR);
   localparam logic [ADDR_W-1:0] A_PMCAP  = ADDR_W'(DW_PMCAP);
   localparam logic [ADDR_W-1:0] A_PMCSR  = ADDR_W'(DW_PMCSR);

   logic        wr_any, rd_any;
   logic        cmdsts_wr, pmcsr_wr;
   logic [15:0] status;
   pstate_e     state;
   logic        enter_d3;
   logic [31:0] rd_mux;
   logic        unused_wdata;

   assign wr_any    = cfg_req &&  cfg_we;
   assign rd_any    = cfg_req && !cfg_we;
   assign cmdsts_wr = wr_any && (cfg_dw_addr == A_CMDSTS);
   assign pmcsr_wr  = wr_any && (cfg_dw_addr == A_PMCSR) && cfg_be[0];
   assign unused_wdata = ^{cfg_wdata[23:16], cfg_wdata[7:2]};

   pcipm_pstate u_pstate (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_stb      (pmcsr_wr),
      .code        (cfg_wdata[1:0]),
      .state       (state),
      .enter_d3    (enter_d3),
      .func_clk_en (func_clk_en),
      .pll_en      (pll_en),
      .soft_rst    (soft_rst)
   );

   pcipm_cmd #(.WR_MASK(CMD_WR_MASK)) u_cmd (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_stb (cmdsts_wr),
      .be     (cfg_be[1:0]),
      .wdata  (cfg_wdata[15:0]),
      .hold   (state == PS_D3HOT),
      .clr    (enter_d3),
      .cmd    (cmd_reg)
   );

   pcipm_status #(.DEVSEL(DEVSEL_TIMING)) u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_stb  (cmdsts_wr && cfg_be[3]),
      .clr_byte (cfg_wdata[31:24]),
      .err_set  (err_set),
      .status   (status)
   );

   always_comb begin
      rd_mux = '0;
      unique case (cfg_dw_addr)
         A_CMDSTS: rd_mux = {status, cmd_reg};
         A_CAPPTR: rd_mux = {24'h0, CAP_LIST_START};
         A_PMCAP:  rd_mux = {PWRMGT_CAPS, CAP_NEXT_NONE, CAP_ID_PWRMGT};
         A_PMCSR:  rd_mux = {30'h0, state};
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_rvalid <= 1'b0;
         cfg_rdata  <= '0;
      end else begin
         cfg_rvalid <= rd_any;
         if (rd_any) cfg_rdata <= rd_mux;
      end
   end

endmodule

// File: rtl/pcipm_cfg_slice_chk.sv
module pcipm_cfg_slice_chk
   import pcipm_pkg::*;
#(
   parameter int unsigned ADDR_W        = 6,
   parameter logic [1:0]  DEVSEL_TIMING = 2'b01
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_req,
   input logic              cfg_we,
   input logic [ADDR_W-1:0] cfg_dw_addr,
   input logic [3:0]        cfg_be,
   input logic [31:0]       cfg_wdata,
   input logic [ERR_N-1:0]  err_set,
   input logic              cfg_rvalid,
   input logic [31:0]       cfg_rdata,
   input logic [15:0]       cmd_reg,
   input logic              func_clk_en,
   input logic              pll_en,
   input logic              soft_rst
);

   localparam logic [ADDR_W-1:0] A_CMDSTS = ADDR_W'(DW_CMDSTS);
   localparam logic [ADDR_W-1:0] A_PMCSR  = ADDR_W'(DW_PMCSR);

   logic rd_pmcsr, rd_cmdsts, rsv_wr;
   assign rd_pmcsr  = cfg_req && !cfg_we && cfg_dw_addr == A_PMCSR;
   assign rd_cmdsts = cfg_req && !cfg_we && cfg_dw_addr == A_CMDSTS;
   assign rsv_wr    = cfg_req && cfg_we && cfg_dw_addr == A_PMCSR && cfg_be[0]
                      && (cfg_wdata[1:0] == 2'b01 || cfg_wdata[1:0] == 2'b10);

   a_r7_sleep_outputs: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |-> (!func_clk_en && !pll_en));

   a_r7_awake_outputs: assert property (@(posedge clk) disable iff (!rst_n)
      !soft_rst |-> (func_clk_en && pll_en));

   a_r8_cmd_zero_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(soft_rst) |-> cmd_reg == 16'h0);

   a_r9_cmd_held_asleep: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |-> cmd_reg == 16'h0);

   a_r10_reserved_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      rsv_wr |=> $stable(soft_rst));

   a_r13_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_req && !cfg_we) |=> cfg_rvalid);

   a_r13_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_req && !cfg_we) |=> !cfg_rvalid);

   a_r4_state_readback: assert property (@(posedge clk) disable iff (!rst_n)
      rd_pmcsr |=> cfg_rdata == {30'h0, soft_rst, soft_rst});

   a_r5_fixed_status_bits: assert property (@(posedge clk) disable iff (!rst_n)
      rd_cmdsts |=> (cfg_rdata[20] && cfg_rdata[26:25] == DEVSEL_TIMING));

endmodule

bind pcipm_cfg_slice pcipm_cfg_slice_chk #(
   .ADDR_W        (ADDR_W),
   .DEVSEL_TIMING (DEVSEL_TIMING)
) u_chk (.*);

// File: tb/tb_pcipm_cfg_slice.sv
`timescale 1ns/1ps
module tb_pcipm_cfg_slice;

   localparam int ADDR_W = 6;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_req = 1'b0;
   logic              cfg_we = 1'b0;
   logic [ADDR_W-1:0] cfg_dw_addr = '0;
   logic [3:0]        cfg_be = '0;
   logic [31:0]       cfg_wdata = '0;
   logic [4:0]        err_set = '0;
   logic              cfg_rvalid;
   logic [31:0]       cfg_rdata;
   logic [15:0]       cmd_reg;
   logic              func_clk_en, pll_en, soft_rst;

   int checks = 0;
   int errors = 0;
   logic [31:0] exp_q [$];
   string       tag_q [$];

   always #4 clk = ~clk;

   pcipm_cfg_slice dut (
      .clk(clk), .rst_n(rst_n), .cfg_req(cfg_req), .cfg_we(cfg_we),
      .cfg_dw_addr(cfg_dw_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
      .err_set(err_set), .cfg_rvalid(cfg_rvalid), .cfg_rdata(cfg_rdata),
      .cmd_reg(cmd_reg), .func_clk_en(func_clk_en), .pll_en(pll_en),
      .soft_rst(soft_rst)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic cfg_wr(input logic [ADDR_W-1:0] a, input logic [3:0] be,
                         input logic [31:0] d, input logic [4:0] ev = 5'b0);
      @(negedge clk);
      cfg_req = 1'b1; cfg_we = 1'b1; cfg_dw_addr = a; cfg_be = be;
      cfg_wdata = d; err_set = ev;
      @(negedge clk);
      cfg_req = 1'b0; cfg_we = 1'b0; err_set = '0;
   endtask

   task automatic cfg_rd(input logic [ADDR_W-1:0] a, input logic [31:0] exp,
                         input string tag);
      @(negedge clk);
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      cfg_req = 1'b1; cfg_we = 1'b0; cfg_dw_addr = a;
      @(negedge clk);
      cfg_req = 1'b0;
   endtask

   task automatic pulse_err(input logic [4:0] ev);
      @(negedge clk);
      err_set = ev;
      @(negedge clk);
      err_set = '0;
   endtask

   task automatic chk_side(input string tag, input logic slp, input logic [15:0] cmd);
      chk({tag, " soft_rst"}, {31'h0, soft_rst}, {31'h0, slp});
      chk({tag, " clk_en"}, {31'h0, func_clk_en}, {31'h0, !slp});
      chk({tag, " pll_en"}, {31'h0, pll_en}, {31'h0, !slp});
      chk({tag, " cmd_reg"}, {16'h0, cmd_reg}, {16'h0, cmd});
   endtask

   // monitor: compares returned reads against the scoreboard
   always @(negedge clk) begin
      if (rst_n && cfg_rvalid) begin
         if (exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R13 unexpected read data actual=%h expected=none", cfg_rdata);
         end else begin
            chk(tag_q.pop_front(), cfg_rdata, exp_q.pop_front());
         end
      end
   end

   initial begin
      #(8 * 20000);
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk_side("R1 reset", 1'b0, 16'h0);
      cfg_rd(6'd1, 32'h0210_0000, "R1 reset status/command");

      cfg_rd(6'd13, 32'h0000_0040, "R2 capability pointer");
      cfg_wr(6'd13, 4'hF, 32'hFFFF_FFFF);
      cfg_rd(6'd13, 32'h0000_0040, "R13 capability pointer read-only");
      cfg_rd(6'd16, 32'h0001_0001, "R3 capability header");
      cfg_wr(6'd16, 4'hF, 32'hFFFF_FFFF);
      cfg_rd(6'd16, 32'h0001_0001, "R13 capability header read-only");
      cfg_rd(6'd17, 32'h0000_0000, "R4 power state D0");
      cfg_rd(6'd5, 32'h0000_0000, "R13 unmapped dword");

      cfg_wr(6'd1, 4'b0011, 32'h0000_FFFF);
      chk("R12 cmd masked", {16'h0, cmd_reg}, 32'h0000_0547);
      cfg_wr(6'd1, 4'b0001, 32'h0000_0000);
      cfg_rd(6'd1, 32'h0210_0500, "R12 cmd byte enable");

      pulse_err(5'b11111);
      cfg_rd(6'd1, 32'hF310_0500, "R6 error flags set");
      cfg_wr(6'd1, 4'b1000, 32'h8000_0000);
      cfg_rd(6'd1, 32'h7310_0500, "R6 clear bit 15 only");
      cfg_wr(6'd1, 4'b0100, 32'hFFFF_0000);
      cfg_rd(6'd1, 32'h7310_0500, "R6 no clear without byte 3");
      cfg_wr(6'd1, 4'b1000, 32'h0100_0000);
      cfg_rd(6'd1, 32'h7210_0500, "R6 clear bit 8");
      cfg_wr(6'd1, 4'b1000, 32'h1000_0000, 5'b00010);
      cfg_rd(6'd1, 32'h7210_0500, "R6 set wins over clear");
      cfg_wr(6'd1, 4'b1100, 32'h0610_0000);
      cfg_rd(6'd1, 32'h7210_0500, "R5 fixed status bits");

      cfg_wr(6'd17, 4'b0001, 32'h0000_0001);
      cfg_rd(6'd17, 32'h0, "R10 code 01 ignored");
      cfg_wr(6'd17, 4'b0001, 32'h0000_0002);
      cfg_rd(6'd17, 32'h0, "R10 code 10 ignored");
      chk_side("R10 still awake", 1'b0, 16'h0500);
      cfg_wr(6'd17, 4'b0010, 32'h0000_0003);
      cfg_rd(6'd17, 32'h0, "R4 no byte 0 enable");

      cfg_wr(6'd17, 4'b0001, 32'h0000_0003);
      chk_side("R7 R8 enter D3hot", 1'b1, 16'h0000);
      cfg_rd(6'd17, 32'h0000_0003, "R4 power state D3hot");
      cfg_wr(6'd1, 4'b0011, 32'h0000_FFFF);
      chk("R9 cmd write ignored", {16'h0, cmd_reg}, 32'h0);
      cfg_wr(6'd17, 4'b0001, 32'h0000_0001);
      repeat (4) @(negedge clk);
      chk_side("R7 R10 held in D3hot", 1'b1, 16'h0000);

      cfg_wr(6'd17, 4'b0001, 32'h0000_0000);
      chk_side("R11 back to D0", 1'b0, 16'h0000);
      cfg_rd(6'd17, 32'h0, "R11 state D0");
      cfg_wr(6'd1, 4'b0011, 32'h0000_0107);
      chk("R11 cmd rewritable", {16'h0, cmd_reg}, 32'h0000_0107);

      repeat (3) @(negedge clk);
      chk("R13 scoreboard drained", exp_q.size(), 32'h0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule